// File: doc/BRIEF.md
# Serial EEPROM Bus Target with Location Pointer

This block is a two-wire serial bus target that behaves like a small byte-wide EEPROM. It samples the clock and data lines with the system clock, passes both through synchronisers, and recognises start and stop conditions and clock edges on the synchronised values. Once a controller has selected it by its 7-bit bus address, the target receives a two-byte location pointer and stores the data bytes that follow. In a read transaction it returns stored bytes from that pointer. It only ever pulls the data line low, and it does so for acknowledge bits and for the zero bits of read data.

A typical random read is a write-addressed transaction that carries only the two pointer bytes, then a repeated start and a read-addressed transaction. The pointer steps by one after every data byte, whether written or read, and it keeps its value across stop conditions. A later read therefore continues where the last access ended. The pointer is 13 bits wide. The byte storage holds 2**STORE_AW bytes, selected by the low pointer bits. With the default of 1024 bytes, pointer values that differ by a multiple of 1024 select the same byte. Setting STORE_AW to 13 gives the full 8192-byte space.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, `sda_pull_low` is 0. It stays 0 whenever no acknowledge bit and no read-data zero bit is due, and in particular while the target is idle.
- R2: A start condition (data falls while the clock is high) from any state, including mid-byte, begins reception of a fresh address byte. A stop condition (data rises while the clock is high) returns the target to idle, where clock pulses are ignored until the next start.
- R3: Data is sampled on clock rising edges, most significant bit first. The target changes `sda_pull_low` only while the synchronised clock is low, so the line is stable for the whole high phase of every bit.
- R4: The first byte after a start is 0xA6 (address 0x53, bit 0 = 0, write) or 0xA7 (bit 0 = 1, read), and it is acknowledged by pulling data low during the ninth clock. Any other address byte gets no acknowledge, and every later byte is ignored until the next start, with no change to memory or pointer.
- R5: In a write transaction, the two bytes after the address are the pointer, high byte first, and each is acknowledged. Only the low 5 bits of the high byte are kept, so high byte 0xE0 with low byte 0x40 gives pointer 0x0040.
- R6: Every further byte of a write transaction is stored at the pointer and acknowledged, and the pointer then advances by one.
- R7: In a read transaction, the target sends the byte at the pointer, most significant bit first, by pulling data low for each 0 bit. It releases data for the ninth clock, and the pointer then advances by one.
- R8: When the controller acknowledges a read byte (data low on the ninth clock), the next byte follows. When it does not (data high), the target keeps data released until the next start or stop.
- R9: The pointer wraps from 0x1FFF to 0x0000. Storage is addressed by the low STORE_AW pointer bits, so with the default depth pointers 0x1FFF and 0x03FF select the same byte.
- R10: The pointer keeps its value across stop conditions and read transactions, so a read-addressed transaction with no pointer bytes continues from the last accessed location plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_pull_low | output | 1 | 1 = pull the data line low; 0 = release it |

## Verification
The assertions check on every cycle that the drive changes only while the synchronised clock is low, that the drive is released while idle or after a rejected address, and that a start always leads to address reception and a stop to a released idle state. They also check that each pointer step adds exactly one, modulo 8192. Only the bench scenarios can show the end-to-end behaviour: the bytes stored are the bytes read back, the upper pointer bits are dropped, the pointer wraps and aliases, the pointer survives across transactions, and foreign addresses, a controller NACK, clocks without a start and restarts mid-byte are all handled. The bench shows these by comparing the drive on every clock of every high phase against a behavioural byte-level model.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // no transaction, clocks ignored
    ST_DEV  = 3'd1,  // receiving the bus address byte
    ST_PHI  = 3'd2,  // receiving pointer high byte
    ST_PLO  = 3'd3,  // receiving pointer low byte
    ST_WDAT = 3'd4,  // receiving data to store
    ST_RDAT = 3'd5,  // sending stored data
    ST_SKIP = 3'd6   // not selected / controller NACK: wait for start or stop
  } tgt_state_e;

  // Bus address comparison on the upper seven bits of the first byte.
  function automatic logic addr_hit(input logic [6:0] upper7, input logic [6:0] own);
    return upper7 == own;
  endfunction

  // Bit of a byte for a given position within the frame, MSB sent first.
  function automatic logic msb_first_bit(input logic [7:0] b, input logic [2:0] pos);
    return b[3'd7 - pos];
  endfunction

endpackage

// File: rtl/i2c_eep_sync.sv
module i2c_eep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  // Idle bus level is high: reset all stages to 1 so no edge appears at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_chain[STAGES-1];
      sda_q     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  // Data edges count as conditions only with the clock held high on both samples.
  assign start_det = scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_eep_store.sv
module i2c_eep_store #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_eep_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h53,
  parameter int unsigned PTR_W       = 13,
  parameter int unsigned STORE_AW    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_low
);

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HI_W      = PTR_W - BYTE_W;
  localparam int unsigned CNT_W     = $clog2(BYTE_W + 1);
  localparam int unsigned POS_W     = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);

  // Bus event wires
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tgt_state_e          state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-2:0]   shreg;
  logic [HI_W-1:0]     ptr_hi;
  logic [PTR_W-1:0]    ptr;
  logic [BYTE_W-1:0]   tx_byte;
  logic                ack_pend;
  logic                rd_dir;

  // Internal events, named for the checker
  logic                active;
  logic                byte_done;
  logic                ack_slot;
  logic                dev_hit;
  logic                mem_we;
  logic                ptr_bump;
  logic                drive_next;
  logic [BYTE_W-1:0]   rx_byte;
  logic [BYTE_W-1:0]   mem_rdata;

  assign rx_byte   = {shreg, sda_s};
  assign active    = (state != ST_IDLE) && (state != ST_SKIP);
  assign byte_done = active && scl_rise && (bit_cnt == LAST_BIT);
  assign ack_slot  = active && scl_rise && (bit_cnt == ACK_BIT);
  assign dev_hit   = addr_hit(rx_byte[BYTE_W-1:1], DEV_ADDR);
  assign mem_we    = byte_done && (state == ST_WDAT);
  assign ptr_bump  = byte_done && ((state == ST_WDAT) || (state == ST_RDAT));

  i2c_eep_store #(.AW(STORE_AW), .DW(BYTE_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ptr[STORE_AW-1:0]),
    .wdata (rx_byte),
    .raddr (ptr[STORE_AW-1:0]),
    .rdata (mem_rdata)
  );

  // Level to present after the next clock fall.
  always_comb begin
    drive_next = 1'b0;
    if (bit_cnt == ACK_BIT) begin
      drive_next = ack_pend;
    end else if (state == ST_RDAT) begin
      drive_next = ~msb_first_bit(tx_byte, bit_cnt[POS_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      shreg        <= '0;
      ptr_hi       <= '0;
      ptr          <= '0;
      tx_byte      <= '0;
      ack_pend     <= 1'b0;
      rd_dir       <= 1'b0;
      sda_pull_low <= 1'b0;
    end else if (start_det) begin
      state        <= ST_DEV;
      bit_cnt      <= '0;
      ack_pend     <= 1'b0;
      sda_pull_low <= 1'b0;
    end else if (stop_det) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      ack_pend     <= 1'b0;
      sda_pull_low <= 1'b0;
    end else begin
      if (active && scl_rise && (bit_cnt != ACK_BIT)) begin
        shreg   <= rx_byte[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
      end

      if (byte_done) begin
        unique case (state)
          ST_DEV: begin
            if (dev_hit) begin
              ack_pend <= 1'b1;
              rd_dir   <= rx_byte[0];
            end else begin
              state    <= ST_SKIP;
            end
          end
          ST_PHI: begin
            ptr_hi   <= rx_byte[HI_W-1:0];
            ack_pend <= 1'b1;
          end
          ST_PLO: begin
            ptr      <= {ptr_hi, rx_byte};
            ack_pend <= 1'b1;
          end
          ST_WDAT: begin
            ptr      <= ptr + 1'b1;
            ack_pend <= 1'b1;
          end
          ST_RDAT: begin
            ptr      <= ptr + 1'b1;
          end
          default: ;
        endcase
      end

      if (ack_slot) begin
        bit_cnt  <= '0;
        ack_pend <= 1'b0;
        unique case (state)
          ST_DEV: begin
            if (rd_dir) begin
              state   <= ST_RDAT;
              tx_byte <= mem_rdata;
            end else begin
              state   <= ST_PHI;
            end
          end
          ST_PHI:  state <= ST_PLO;
          ST_PLO:  state <= ST_WDAT;
          ST_WDAT: state <= ST_WDAT;
          ST_RDAT: begin
            if (sda_s) state   <= ST_SKIP;   // controller NACK
            else       tx_byte <= mem_rdata; // pointer already advanced
          end
          default: ;
        endcase
      end

      if (active && scl_fall) begin
        sda_pull_low <= drive_next;
      end
    end
  end

endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk
  import i2c_eep_pkg::*;
#(
  parameter int unsigned PTR_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             ptr_bump,
  input logic [PTR_W-1:0] ptr,
  input tgt_state_e       state,
  input logic             sda_pull_low
);

  // R3
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> !$past(scl_s));

  // R2
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_pull_low);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_low);

  // R4
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_pull_low);

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_bump && !start_det && !stop_det) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_s        (scl_s),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .ptr_bump     (ptr_bump),
  .ptr          (ptr),
  .state        (state),
  .sda_pull_low (sda_pull_low)
);

// File: tb/i2c_eeprom_target_test.sv
`timescale 1ns/1ps
module i2c_eeprom_target_test;

  localparam int HP    = 8;       // clocks per bus half period
  localparam int DEPTH = 1024;    // default storage depth
  localparam int SPAN  = 8192;    // pointer range

  logic clk = 1'b0;
  always #4 clk = ~clk;           // 125 MHz

  logic rst_n;
  logic m_scl;
  logic m_sda;
  logic pull;
  logic sda_bus;
  assign sda_bus = m_sda & ~pull;

  i2c_eeprom_target uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (m_scl),
    .sda_i        (sda_bus),
    .sda_pull_low (pull)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  logic  exp_valid = 1'b0;
  logic  exp_pull  = 1'b0;
  string cur_req   = "R1";
  logic  finished  = 1'b0;

  logic [7:0] model_mem [int];
  int         model_ptr = 0;

  // Per-clock comparison of the drive during every high phase.
  always @(negedge clk) begin
    if (exp_valid && !finished) begin
      n_cmp++;
      if (pull !== exp_pull) begin
        n_bad++;
        $display("FAIL %s: sda_pull_low=%0b expected %0b at %0t", cur_req, pull, exp_pull, $time);
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HP/2);
    m_scl = 1'b1; tick(HP/2);
    m_sda = 1'b0; tick(HP/2);
    m_scl = 1'b0; tick(HP/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP/2);
    m_scl = 1'b1; tick(HP/2);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic clk_bit(input logic b, input logic ep, output logic seen);
    m_sda = b; tick(HP/2);
    m_scl = 1'b1; exp_pull = ep; exp_valid = 1'b1;
    tick(HP/2);
    seen = sda_bus;
    tick(HP/2);
    exp_valid = 1'b0; m_scl = 1'b0;
    tick(HP/2);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic exp_ack, input string req);
    logic seen;
    cur_req = req;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], 1'b0, seen);
    clk_bit(1'b1, exp_ack, seen);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
    logic [7:0] got;
    logic       seen;
    cur_req = req;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~exp[i], seen);
      got[i] = seen;
    end
    chk(req, got, exp);
    cur_req = "R7 ninth clock released";
    clk_bit(~mack, 1'b0, seen);
  endtask

  task automatic set_ptr(input logic [15:0] p, input string req);
    send_byte(8'hA6, 1'b1, "R4 write address ack");
    send_byte(p[15:8], 1'b1, req);
    send_byte(p[7:0],  1'b1, req);
    model_ptr = int'(p) & (SPAN - 1);
  endtask

  task automatic write_txn(input logic [15:0] p, input logic [7:0] data [$], input string req);
    bus_start();
    set_ptr(p, "R5 pointer byte ack");
    foreach (data[k]) begin
      send_byte(data[k], 1'b1, req);
      model_mem[model_ptr % DEPTH] = data[k];
      model_ptr = (model_ptr + 1) % SPAN;
    end
    bus_stop();
  endtask

  task automatic read_body(input int n, input string req);
    send_byte(8'hA7, 1'b1, "R4 read address ack");
    for (int k = 0; k < n; k++) begin
      recv_byte(model_mem[model_ptr % DEPTH], (k != n - 1), req);
      model_ptr = (model_ptr + 1) % SPAN;
    end
  endtask

  task automatic random_read(input logic [15:0] p, input int n, input string req);
    bus_start();
    set_ptr(p, "R5 pointer byte ack");
    bus_start();
    read_body(n, req);
    bus_stop();
  endtask

  task automatic plain_read(input int n, input string req);
    bus_start();
    read_body(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      summary();
    end
  end

  initial begin
    logic seen;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    tick(5);
    chk("R1 drive in reset", {7'd0, pull}, 8'h00);
    rst_n = 1'b1;
    tick(10);
    chk("R1 drive after reset", {7'd0, pull}, 8'h00);

    // R6 single byte store, R7 read back by random read (R3 bus sampling)
    write_txn(16'h1D00, '{8'h05}, "R6 data byte ack");
    random_read(16'h1D00, 1, "R7 R3 read byte");

    // R6 burst store, R8 controller ACK continues the burst
    write_txn(16'h0123, '{8'h11, 8'h22, 8'h33, 8'h44}, "R6 burst data ack");
    random_read(16'h0123, 4, "R8 burst read");

    // R10 pointer survives stop: plain read continues after last location
    random_read(16'h0123, 2, "R10 first part");
    plain_read(2, "R10 continued read");

    // R5 upper three bits of high pointer byte discarded
    write_txn(16'hE040, '{8'h77}, "R5 masked pointer store");
    random_read(16'h0040, 1, "R5 masked pointer readback");

    // R9 wrap from 0x1FFF to 0x0000 and storage aliasing
    write_txn(16'h1FFF, '{8'hAA, 8'hBB}, "R9 wrap store");
    random_read(16'h1FFF, 2, "R9 wrap read");
    random_read(16'h03FF, 1, "R9 alias read");

    // R4 foreign address: no ack, following bytes ignored, nothing changed
    bus_start();
    send_byte(8'h50, 1'b0, "R4 foreign address no ack");
    send_byte(8'h00, 1'b0, "R4 ignored byte");
    send_byte(8'h40, 1'b0, "R4 ignored byte");
    send_byte(8'h99, 1'b0, "R4 ignored byte");
    bus_stop();
    plain_read(1, "R4 pointer and memory untouched");

    // R8 controller NACK: data released for following clocks
    bus_start();
    set_ptr(16'h0123, "R5 pointer byte ack");
    bus_start();
    send_byte(8'hA7, 1'b1, "R4 read address ack");
    recv_byte(model_mem[model_ptr % DEPTH], 1'b0, "R8 byte before nack");
    model_ptr = (model_ptr + 1) % SPAN;
    send_byte(8'hFF, 1'b0, "R8 released after nack");
    bus_stop();

    // R2 clocks without a start are ignored after stop
    m_scl = 1'b0; tick(HP/2);
    send_byte(8'hA6, 1'b0, "R2 idle ignores address");
    send_byte(8'hA7, 1'b0, "R2 idle ignores address");

    // R2 start in the middle of a pointer byte restarts address reception
    bus_start();
    send_byte(8'hA6, 1'b1, "R4 write address ack");
    cur_req = "R2 partial byte";
    clk_bit(1'b0, 1'b0, seen);
    clk_bit(1'b0, 1'b0, seen);
    clk_bit(1'b1, 1'b0, seen);
    bus_start();
    read_body(1, "R2 read after mid-byte restart");
    bus_stop();

    tick(20);
    chk("R1 released at end", {7'd0, pull}, 8'h00);
    summary();
  end

endmodule